// File: doc/BRIEF.md
# Adaptive-Prescale Multichannel Period Meter

This block measures the rotation period of a bank of motors at the same time, one channel for each tachometer pulse train. Each channel divides its input edges by a power-of-two prescale factor and counts a fast reference clock across the resulting interval. It moves its prescale exponent up or down by one step after each interval, so the tick count stays inside a window that keeps the required relative resolution at every speed. A fixed-length measurement frame drives the block. At the end of each frame every channel posts its most recent count and the exponent used for it into a result bank. A channel that completes no interval during the frame reports itself as stopped.

A 16-bit host bus reads the bank. A read strobe with an address returns one data word one cycle later. Reading the first word of a channel snapshots that channel's count, and the snapshot is held until the host reads the last count word. A host that reads a channel's words in order therefore never sees two different frames mixed together.

Each channel runs a two-state machine. ARM waits for the first synchronised rising edge. RUN counts ticks and prescaled edges. The transition ARM→RUN happens on a rising edge. The transition RUN→ARM (and ARM→ARM) happens at a frame end when the channel completed no interval in that frame. Each channel's snapshot register runs a second two-state machine. OPEN tracks the bank. HELD keeps its value. The transition OPEN→HELD happens on a read of word 0. The transition HELD→OPEN happens on a read of the last count word.

Top module: `period_meter_bank`

## Requirements
- R1: Each channel is independent. A steady square wave with a period of P reference cycles on a channel yields a count of exactly P·2^e, where e is the exponent that channel reports.
- R2: Each input passes through a two-flop synchroniser, and only rising edges advance the prescaler. With exponent e, one interval spans 2^e rising edges, and word 0 reports e in bits 2:0.
- R3: When a completed count is below FLOOR and the exponent is below 7, the next interval uses the exponent plus one.
- R4: When a completed count exceeds 2^CEIL_LOG2 and the exponent is above 0, the next interval uses the exponent minus one.
- R5: The exponent stays within 0 to 7. A count above the ceiling at exponent 0, or below the floor at exponent 7, leaves the exponent unchanged.
- R6: A channel that completes no interval within a frame reports stopped = 1 (word 0 bit 14), a count of 0 and an exponent of 0. It then restarts from exponent 0 on its next rising edge.
- R7: The bank is updated only at the end of each frame, once every FRAME_TICKS reference cycles.
- R8: Address map. Address 0 is status. Channel c uses base address 4+4c: word 0 holds {bit15 = bank valid, bit14 = stopped, bits 2:0 = exponent}, word 1 holds count bits 15:0, and word 2 holds count bits 31:16.
- R9: A read of word 0 freezes that channel's count words until its last count word has been read.
- R10: Status bit 0 (frame done) is set when the bank updates and cleared by a read of address 0.
- R11: After reset, every readable word is 0.
- R12: rd_valid rises exactly one cycle after each rd_en, and rd_data carries the word for that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also clocks the host bus |
| rst_n | input | 1 | Active-low synchronous reset |
| tach_in | input | NCH | One asynchronous tachometer pulse input per channel |
| rd_en | input | 1 | Host read strobe, one cycle per read |
| rd_addr | input | ADDR_W | Host word address |
| rd_data | output | 16 | Read data, valid while rd_valid is high |
| rd_valid | output | 1 | Marks the cycle after a read strobe |

## Verification
The bench builds the block with eight channels, FLOOR = 300, CEIL_LOG2 = 12 and an 11000-cycle frame. With these values every channel settles within a few thousand cycles, and several frames fit inside the run. Under these settings a two-cycle input reaches the exponent cap of 7, a 5000-cycle input stays at exponent 0 above the ceiling, and a slowdown from exponent 7 steps down to 5. Holding an input still produces the stopped report and then a restart from exponent 0. The frame is short enough that a frame update can be placed between two reads of the same channel to test the freeze.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
    typedef enum logic {CH_ARM = 1'b0, CH_RUN = 1'b1} ch_state_e;
    typedef enum logic {FZ_OPEN = 1'b0, FZ_HELD = 1'b1} fz_state_e;
    localparam int HOST_W = 16;
endpackage

// File: rtl/pmb_frame_timer.sv
module pmb_frame_timer #(
    parameter int FRAME_TICKS = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic frame_tick
);
    localparam int W = (FRAME_TICKS > 2) ? $clog2(FRAME_TICKS) : 1;
    localparam logic [W-1:0] LAST = W'(FRAME_TICKS - 1);

    logic [W-1:0] cnt_q;

    assign frame_tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (frame_tick) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> (cnt_q == '0 && !frame_tick)); // R7
endmodule

// File: rtl/pmb_channel.sv
module pmb_channel import pmb_pkg::*; #(
    parameter int CNT_W     = 32,
    parameter int EXP_W     = 3,
    parameter int FLOOR     = 10000,
    parameter int CEIL_LOG2 = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tach_in,
    input  logic             frame_tick,
    output logic [CNT_W-1:0] rep_count,
    output logic [EXP_W-1:0] rep_exp,
    output logic             rep_stopped
);
    localparam int PRE_W = (1 << EXP_W) - 1;
    localparam logic [EXP_W-1:0] EXP_MAX   = '1;
    localparam logic [CNT_W:0]   CEIL_VAL  = (CNT_W+1)'(1) << CEIL_LOG2;
    localparam logic [CNT_W:0]   FLOOR_VAL = (CNT_W+1)'(FLOOR);
    localparam logic [CNT_W-1:0] CNT_SAT   = '1;

    logic [2:0]       sync_q;
    logic             rise;
    ch_state_e        st_q, st_d;
    logic [CNT_W-1:0] tick_q, meas, last_cnt_q;
    logic [PRE_W-1:0] pre_q, pre_last;
    logic [EXP_W-1:0] exp_q, exp_adapt, last_exp_q;
    logic             got_q, done_now, stop_now, too_short, too_long;

    assign rise      = sync_q[1] & ~sync_q[2];
    assign meas      = (tick_q == CNT_SAT) ? CNT_SAT : tick_q + 1'b1;
    assign done_now  = (st_q == CH_RUN) && rise && (pre_q == pre_last);
    assign stop_now  = frame_tick && !got_q;
    assign too_short = ({1'b0, meas} < FLOOR_VAL);
    assign too_long  = ({1'b0, meas} > CEIL_VAL);

    always_comb begin
        for (int i = 0; i < PRE_W; i++) pre_last[i] = (i < int'(exp_q));
    end

    always_comb begin
        exp_adapt = exp_q;
        if (too_short && exp_q != EXP_MAX)  exp_adapt = exp_q + 1'b1;
        else if (too_long && exp_q != '0)   exp_adapt = exp_q - 1'b1;
    end

    // state machine: next state
    always_comb begin
        st_d = st_q;
        if (stop_now) st_d = CH_ARM;
        else begin
            unique case (st_q)
                CH_ARM: if (rise) st_d = CH_RUN;
                CH_RUN: st_d = CH_RUN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_ARM;
        else        st_q <= st_d;
    end

    // datapath and reports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q      <= '0;
            tick_q      <= '0;
            pre_q       <= '0;
            exp_q       <= '0;
            last_cnt_q  <= '0;
            last_exp_q  <= '0;
            got_q       <= 1'b0;
            rep_count   <= '0;
            rep_exp     <= '0;
            rep_stopped <= 1'b0;
        end else begin
            sync_q <= {sync_q[1:0], tach_in};
            if (stop_now) begin
                tick_q <= '0;
                pre_q  <= '0;
                exp_q  <= '0;
            end else if (st_q == CH_ARM) begin
                tick_q <= '0;
                pre_q  <= '0;
            end else if (done_now) begin
                last_cnt_q <= meas;
                last_exp_q <= exp_q;
                exp_q      <= exp_adapt;
                tick_q     <= '0;
                pre_q      <= '0;
            end else begin
                tick_q <= meas;
                if (rise) pre_q <= pre_q + 1'b1;
            end

            if (frame_tick) got_q <= got_q & done_now;
            else if (done_now) got_q <= 1'b1;

            if (frame_tick) begin
                rep_count   <= got_q ? last_cnt_q : '0;
                rep_exp     <= got_q ? last_exp_q : '0;
                rep_stopped <= !got_q;
            end
        end
    end

    AST_EXP_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_q != $past(exp_q)) |-> (exp_q == $past(exp_q) + 1'b1 || exp_q == $past(exp_q) - 1'b1 || exp_q == '0)); // R3
    AST_RAISE_ON_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (done_now && !frame_tick && too_short && exp_q != EXP_MAX) |=> (exp_q == $past(exp_q) + 1'b1)); // R3
    AST_LOWER_ON_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (done_now && !frame_tick && too_long && exp_q != '0) |=> (exp_q == $past(exp_q) - 1'b1)); // R4
    AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rep_stopped |-> (rep_count == '0 && rep_exp == '0)); // R6
    AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_RUN) |-> (pre_q <= pre_last)); // R2
endmodule

// File: rtl/pmb_host_port.sv
module pmb_host_port import pmb_pkg::*; #(
    parameter int NCH    = 8,
    parameter int CNT_W  = 32,
    parameter int EXP_W  = 3,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic [CNT_W-1:0]  rep_count   [NCH],
    input  logic [EXP_W-1:0]  rep_exp     [NCH],
    input  logic              rep_stopped [NCH],
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [HOST_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int CW    = (CNT_W + HOST_W - 1) / HOST_W;
    localparam int PAD_W = CW * HOST_W;
    localparam int BLK_W = ADDR_W - 2;

    logic              frame_done_q, bank_valid_q;
    logic [BLK_W-1:0]  blk;
    logic [1:0]        word;
    logic              hit_first [NCH];
    logic              hit_last  [NCH];
    fz_state_e         fz_q [NCH];
    logic [CNT_W-1:0]  shadow_q [NCH];
    logic [HOST_W-1:0] data_d;

    assign blk  = rd_addr[ADDR_W-1:2];
    assign word = rd_addr[1:0];

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        fz_state_e fz_d;
        assign hit_first[c] = rd_en && (blk == BLK_W'(c + 1)) && (word == 2'd0);
        assign hit_last[c]  = rd_en && (blk == BLK_W'(c + 1)) && (word == 2'(CW));

        always_comb begin
            fz_d = fz_q[c];
            unique case (fz_q[c])
                FZ_OPEN: if (hit_first[c]) fz_d = FZ_HELD;
                FZ_HELD: if (hit_last[c] && !hit_first[c]) fz_d = FZ_OPEN;
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) fz_q[c] <= FZ_OPEN;
            else        fz_q[c] <= fz_d;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) shadow_q[c] <= '0;
            else if (fz_q[c] == FZ_OPEN || hit_first[c]) shadow_q[c] <= rep_count[c];
        end

        AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (fz_q[c] == FZ_HELD && !hit_first[c]) |=> $stable(shadow_q[c])); // R9
    end

    always_comb begin
        logic [PAD_W-1:0] pad;
        data_d = '0;
        pad    = '0;
        if (rd_addr == '0) data_d = {{(HOST_W-1){1'b0}}, frame_done_q};
        for (int c = 0; c < NCH; c++) begin
            if (blk == BLK_W'(c + 1)) begin
                pad = PAD_W'(shadow_q[c]);
                if (word == 2'd0)
                    data_d = {bank_valid_q, rep_stopped[c], {(HOST_W-2-EXP_W){1'b0}}, rep_exp[c]};
                for (int k = 1; k <= CW; k++)
                    if (word == 2'(k)) data_d = pad[HOST_W*(k-1) +: HOST_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_done_q <= 1'b0;
            bank_valid_q <= 1'b0;
            rd_data      <= '0;
            rd_valid     <= 1'b0;
        end else begin
            if (frame_tick)                      frame_done_q <= 1'b1;
            else if (rd_en && rd_addr == '0)     frame_done_q <= 1'b0;
            if (frame_tick) bank_valid_q <= 1'b1;
            rd_valid <= rd_en;
            if (rd_en) rd_data <= data_d;
        end
    end

    AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == '0 && !frame_tick) |=> !frame_done_q); // R10
    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> (frame_done_q && bank_valid_q)); // R10
endmodule

// File: rtl/period_meter_bank.sv
module period_meter_bank #(
    parameter int NCH         = 8,
    parameter int CNT_W       = 32,
    parameter int EXP_W       = 3,
    parameter int FLOOR       = 10000,
    parameter int CEIL_LOG2   = 24,
    parameter int FRAME_TICKS = 50_000_000,
    localparam int ADDR_W     = $clog2(4 * (NCH + 1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    tach_in,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data,
    output logic              rd_valid
);
    logic             frame_tick;
    logic [CNT_W-1:0] rep_count   [NCH];
    logic [EXP_W-1:0] rep_exp     [NCH];
    logic             rep_stopped [NCH];

    pmb_frame_timer #(.FRAME_TICKS(FRAME_TICKS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pmb_channel #(
            .CNT_W     (CNT_W),
            .EXP_W     (EXP_W),
            .FLOOR     (FLOOR),
            .CEIL_LOG2 (CEIL_LOG2)
        ) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .tach_in     (tach_in[c]),
            .frame_tick  (frame_tick),
            .rep_count   (rep_count[c]),
            .rep_exp     (rep_exp[c]),
            .rep_stopped (rep_stopped[c])
        );
    end

    pmb_host_port #(
        .NCH    (NCH),
        .CNT_W  (CNT_W),
        .EXP_W  (EXP_W),
        .ADDR_W (ADDR_W)
    ) u_host (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_tick  (frame_tick),
        .rep_count   (rep_count),
        .rep_exp     (rep_exp),
        .rep_stopped (rep_stopped),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid)
    );
endmodule

// File: tb/sim_period_meter_bank.sv
`timescale 1ns/1ps
module sim_period_meter_bank;
    localparam int NCH       = 8;
    localparam int FLOOR     = 300;
    localparam int CEIL_LOG2 = 12;
    localparam int FRAME     = 11000;
    localparam int ADDR_W    = $clog2(4 * (NCH + 1));

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n;
    logic [NCH-1:0]    tach;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [15:0]       rd_data;
    logic              rd_valid;

    int per [NCH] = '{10, 2, 5000, 4, 30, 10, 7, 1000};
    int n_chk = 0;
    int n_err = 0;

    logic [15:0] exp_q [$];
    bit          chk_q [$];
    string       tag_q [$];
    logic [15:0] last_data = '0;
    logic [15:0] m_exp;
    bit          m_chk;
    string       m_tag;

    period_meter_bank #(
        .NCH(NCH), .CNT_W(32), .EXP_W(3), .FLOOR(FLOOR),
        .CEIL_LOG2(CEIL_LOG2), .FRAME_TICKS(FRAME)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tach_in(tach), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_src
        logic src = 1'b0;
        assign tach[g] = src;
        initial begin
            forever begin
                if (per[g] < 2) @(negedge clk);
                else begin
                    src = 1'b1;
                    repeat (per[g] / 2) @(negedge clk);
                    src = 1'b0;
                    repeat (per[g] - per[g] / 2) @(negedge clk);
                end
            end
        end
    end

    // monitor: pops the scoreboard as read data appears
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL R12: unexpected read data %h, expected none", rd_data);
            end else begin
                m_exp = exp_q.pop_front();
                m_chk = chk_q.pop_front();
                m_tag = tag_q.pop_front();
                last_data = rd_data;
                if (m_chk) begin
                    n_chk++;
                    if (rd_data !== m_exp) begin
                        n_err++;
                        $display("FAIL %s: actual %h expected %h", m_tag, rd_data, m_exp);
                    end
                end
            end
        end
    end

    task automatic rd(input int a, input logic [15:0] e, input bit c, input string t);
        @(negedge clk);
        exp_q.push_back(e); chk_q.push_back(c); tag_q.push_back(t);
        rd_addr = ADDR_W'(a);
        rd_en   = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        if (c) begin
            n_chk++;
            if (rd_valid !== 1'b1) begin
                n_err++;
                $display("FAIL R12 %s: rd_valid actual %b expected 1", t, rd_valid);
            end
        end
        @(posedge clk);
    endtask

    task automatic wait_frame();
        do rd(0, 16'h0, 1'b0, "poll"); while (last_data[0] !== 1'b1);
    endtask

    function automatic int settle(input int p, input int e0);
        int e = e0;
        for (int i = 0; i < 20; i++) begin
            if ((p << e) < FLOOR && e < 7) e++;
            else if ((p << e) > (1 << CEIL_LOG2) && e > 0) e--;
            else break;
        end
        return e;
    endfunction

    task automatic chk_ch(input int ch, input int p, input int e, input string t);
        logic [31:0] cnt = 32'(p << e);
        int base = 4 + 4 * ch;
        rd(base,     {1'b1, 1'b0, 11'b0, 3'(e)}, 1'b1, {t, " word0"});
        rd(base + 1, cnt[15:0],                  1'b1, {t, " count low"});
        rd(base + 2, cnt[31:16],                 1'b1, {t, " count high"});
    endtask

    string tags [NCH] = '{"R1 R3 R8 ch0", "R5 cap high ch1", "R4 R5 cap low ch2", "R5 cap high ch3",
                          "R3 ch4", "R1 R2 ch5", "R1 R2 ch6", "R1 R2 ch7"};

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rd_en = 1'b0; rd_addr = '0;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;

        rd(0, 16'h0, 1'b1, "R11 status after reset");
        rd(4, 16'h0, 1'b1, "R11 ch0 word0 after reset");
        rd(5, 16'h0, 1'b1, "R11 ch0 count after reset");

        repeat (3) wait_frame();
        rd(0, 16'h0, 1'b1, "R10 frame done cleared by status read");
        for (int ch = 0; ch < NCH; ch++) chk_ch(ch, per[ch], settle(per[ch], 0), tags[ch]);

        wait_frame();
        repeat (FRAME - 200) @(negedge clk);
        rd(0, 16'h0, 1'b1, "R7 no update before frame end");
        repeat (300) @(negedge clk);
        rd(0, 16'h1, 1'b1, "R7 R10 update at frame end");

        wait_frame();
        rd(24, {1'b1, 1'b0, 11'b0, 3'(settle(10, 0))}, 1'b1, "R9 ch5 word0");
        per[5] = 20;
        repeat (2) wait_frame();
        rd(25, 16'(10 << settle(10, 0)), 1'b1, "R9 ch5 frozen count low");
        rd(26, 16'h0, 1'b1, "R9 ch5 frozen count high");

        per[3] = 80;
        per[4] = 0;
        repeat (4) wait_frame();
        chk_ch(3, 80, settle(80, 7), "R4 ch3 slowdown");
        rd(20, {1'b1, 1'b1, 14'b0}, 1'b1, "R6 ch4 stopped word0");
        rd(21, 16'h0, 1'b1, "R6 ch4 stopped count low");
        rd(22, 16'h0, 1'b1, "R6 ch4 stopped count high");
        chk_ch(5, 20, settle(20, settle(10, 0)), "R9 ch5 released");

        per[4] = 30;
        repeat (2) wait_frame();
        chk_ch(4, 30, settle(30, 0), "R6 ch4 restart");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule